// File: doc/BRIEF.md
# Channel Parameter Write Guard

This block sits between a host register bus and the parameter storage of one communication channel. The storage is split into a transmit region and a receive region. The block follows the host's channel commands and tracks whether each direction is running or quiescent. A write reaches a region only while that direction is quiescent. Reads are served at all times. A write that arrives while its region is locked is dropped. The block answers it with a denied response and a one-cycle error pulse.

The transmit side has three states: running, draining and halted. An immediate stop halts the transmitter at once. A graceful stop first drains: the region stays locked until the transmitter reports that the frame in flight has finished. Either kind of halt lasts until a restart command. The receive side is on or off, and only the off state opens its region. Closing the current receive buffer does not stop reception, so that command leaves the receive region locked. The receive-buffer length limit is stored in the receive region and is also presented on a dedicated output for the receive datapath.

Host accesses use a valid/ready request channel and a valid/ready response channel. Every accepted request produces exactly one response beat, and responses come back in request order. The request channel accepts a new beat only when the response register is empty or is being drained in the same cycle. While the response is stalled (`rsp_valid` high and `rsp_ready` low), `req_ready` is low and the response payload holds steady.

Top module: `chan_param_guard`

## Requirements
- R1: After reset the transmitter is halted (`tx_writable`=1, `tx_draining`=0), the receiver is off (`rx_writable`=1), `rsp_valid`=0, `wr_err`=0, and every parameter word reads as zero.
- R2: A read of any address is accepted in every transmit and receive state. Its response arrives on the cycle after acceptance with `rsp_denied`=0 and the stored word in `rsp_rdata`.
- R3: An immediate stop command makes `tx_writable` 1 from the next cycle. While halted, transmit-region writes (address MSB = 0) are stored.
- R4: A graceful stop issued while running enters draining: `tx_draining`=1 and `tx_writable`=0. The block stays in draining until a frame-done pulse arrives, and the cycle after that pulse it is halted and writable.
- R5: A restart command returns the transmitter to running from either the draining or the halted state. In running, transmit-region writes are denied.
- R6: A stop command issued while draining halts the transmitter on the next cycle, without waiting for frame-done.
- R7: Receive-region writes (address MSB = 1) are stored only while the receiver is off. A receive enable command locks the region and a receive disable command opens it, each from the next cycle.
- R8: The close-receive-buffer command never changes `rx_writable` in either receiver state.
- R9: A denied write leaves memory unchanged. It returns a response with `rsp_denied`=1 and `rsp_rdata`=0. `wr_err` is high for exactly the cycle in which that response first appears.
- R10: `rx_max_len` always shows receive word 0 (address 8 with the default depth of 8 words per region).
- R11: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the response payload is held. A request held pending during the stall is accepted on the edge that drains the response.
- R12: Simultaneous commands resolve by priority. Stop beats restart, and restart beats graceful stop. Receive disable beats receive enable. A frame-done pulse outside draining is ignored.
- R13: An accepted write returns a response with `rsp_denied`=0 and `rsp_rdata`=0. The written word is visible to a read accepted on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (4) | MSB selects region (0 transmit, 1 receive); low bits select the word |
| req_wdata | input | DW (16) | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | DW (16) | Read data; zero for writes |
| rsp_denied | output | 1 | Write was blocked by the guard |
| cmd_tx_stop | input | 1 | Immediate transmit stop pulse |
| cmd_tx_graceful | input | 1 | Graceful transmit stop pulse |
| cmd_tx_restart | input | 1 | Transmit restart pulse |
| cmd_rx_enable | input | 1 | Receiver enable pulse |
| cmd_rx_disable | input | 1 | Receiver disable pulse |
| cmd_rx_close_buf | input | 1 | Close current receive buffer pulse |
| tx_frame_done | input | 1 | Transmitter finished the frame in flight |
| tx_writable | output | 1 | Transmit region open for writes |
| tx_draining | output | 1 | Graceful stop waiting for frame end |
| rx_writable | output | 1 | Receive region open for writes |
| wr_err | output | 1 | One-cycle pulse for a denied write |
| rx_max_len | output | DW (16) | Receive buffer length limit (receive word 0) |

## Verification
The bench first targets the draining window. It sends a frame-done pulse while running and a write while draining, so a design that opened the region on the graceful command itself, or that latched a stray frame-done, would store data it should drop. It then issues a stop in the middle of draining and pairs commands in the same cycle, which catches a design with a wrong priority that stays locked or restarts when it should halt. On the receive side, close-buffer is sent in both receiver states, so a design that treated it as a disable would open the region. A stalled response with a second request waiting exposes a design that overwrites or loses a beat under back-pressure.

// File: rtl/pguard_pkg.sv
package pguard_pkg;

  typedef enum logic [1:0] {
    TX_RUNNING  = 2'd0,
    TX_DRAINING = 2'd1,
    TX_HALTED   = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic stop;
    logic graceful;
    logic restart;
    logic frame_done;
  } tx_cmd_t;

  typedef struct packed {
    logic enable;
    logic disable_rx;
    logic close_buf;
  } rx_cmd_t;

  localparam int unsigned NUM_REGIONS = 2;
  localparam int unsigned REGION_TX   = 0;
  localparam int unsigned REGION_RX   = 1;

endpackage

// File: rtl/pguard_tx_ctrl.sv
module pguard_tx_ctrl
  import pguard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tx_cmd_t cmd,
  output logic    writable,
  output logic    draining
);

  tx_state_e st_q;
  tx_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (cmd.stop) begin
      st_d = TX_HALTED;
    end else if (cmd.restart) begin
      st_d = TX_RUNNING;
    end else begin
      case (st_q)
        TX_RUNNING:  if (cmd.graceful)   st_d = TX_DRAINING;
        TX_DRAINING: if (cmd.frame_done) st_d = TX_HALTED;
        default:     st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= TX_HALTED;
    else        st_q <= st_d;
  end

  assign writable = (st_q == TX_HALTED);
  assign draining = (st_q == TX_DRAINING);

endmodule

// File: rtl/pguard_rx_ctrl.sv
module pguard_rx_ctrl
  import pguard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  rx_cmd_t cmd,
  output logic    writable
);

  logic on_q;
  logic on_d;

  always_comb begin
    on_d = on_q;
    if (cmd.disable_rx)     on_d = 1'b0;
    else if (cmd.enable)    on_d = 1'b1;
    else if (cmd.close_buf) on_d = on_q;  // buffer hand-back only; reception continues
  end

  always_ff @(posedge clk) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_d;
  end

  assign writable = !on_q;

endmodule

// File: rtl/pguard_param_bank.sv
module pguard_param_bank #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [DW-1:0]       wdata,
  output logic [WORDS*DW-1:0] words_flat
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                        word_q <= '0;
      else if (we && (widx == IW'(w)))   word_q <= wdata;
    end

    assign words_flat[w*DW +: DW] = word_q;
  end

endmodule

// File: rtl/chan_param_guard.sv
module chan_param_guard
  import pguard_pkg::*;
#(
  parameter int unsigned WORDS         = 8,
  parameter int unsigned DW            = 16,
  parameter int unsigned RX_MAXLEN_IDX = 0,
  localparam int unsigned IW           = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned AW           = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_denied,
  input  logic          cmd_tx_stop,
  input  logic          cmd_tx_graceful,
  input  logic          cmd_tx_restart,
  input  logic          cmd_rx_enable,
  input  logic          cmd_rx_disable,
  input  logic          cmd_rx_close_buf,
  input  logic          tx_frame_done,
  output logic          tx_writable,
  output logic          tx_draining,
  output logic          rx_writable,
  output logic          wr_err,
  output logic [DW-1:0] rx_max_len
);

  tx_cmd_t tx_cmd;
  rx_cmd_t rx_cmd;

  assign tx_cmd = '{stop: cmd_tx_stop, graceful: cmd_tx_graceful,
                    restart: cmd_tx_restart, frame_done: tx_frame_done};
  assign rx_cmd = '{enable: cmd_rx_enable, disable_rx: cmd_rx_disable,
                    close_buf: cmd_rx_close_buf};

  pguard_tx_ctrl u_tx_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (tx_cmd),
    .writable (tx_writable),
    .draining (tx_draining)
  );

  pguard_rx_ctrl u_rx_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (rx_cmd),
    .writable (rx_writable)
  );

  // Request decode
  logic                   accept;
  logic                   region;
  logic [IW-1:0]          idx;
  logic [NUM_REGIONS-1:0] open_vec;
  logic                   allow;
  logic                   deny;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign region    = req_addr[AW-1];
  assign idx       = req_addr[IW-1:0];

  assign open_vec[REGION_TX] = tx_writable;
  assign open_vec[REGION_RX] = rx_writable;
  assign allow               = open_vec[region];
  assign deny                = accept && req_write && !allow;

  // Storage, one bank per region
  logic [WORDS*DW-1:0] bank_flat [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic we_g;
    assign we_g = accept && req_write && allow && (region == 1'(g));

    pguard_param_bank #(
      .WORDS (WORDS),
      .DW    (DW)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (we_g),
      .widx       (idx),
      .wdata      (req_wdata),
      .words_flat (bank_flat[g])
    );
  end

  logic [DW-1:0] rd_sel;
  assign rd_sel     = bank_flat[region][idx*DW +: DW];
  assign rx_max_len = bank_flat[REGION_RX][RX_MAXLEN_IDX*DW +: DW];

  // Response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_denied <= 1'b0;
      wr_err     <= 1'b0;
    end else begin
      wr_err <= deny;
      if (accept) begin
        rsp_valid  <= 1'b1;
        rsp_rdata  <= req_write ? '0 : rd_sel;
        rsp_denied <= deny;
      end else if (rsp_ready) begin
        rsp_valid  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pguard_checker.sv
module pguard_checker #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_denied,
  input logic          cmd_tx_stop,
  input logic          cmd_tx_graceful,
  input logic          cmd_tx_restart,
  input logic          cmd_rx_enable,
  input logic          cmd_rx_disable,
  input logic          cmd_rx_close_buf,
  input logic          tx_frame_done,
  input logic          tx_writable,
  input logic          tx_draining,
  input logic          rx_writable,
  input logic          wr_err
);

  assert_read_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (rsp_valid && !rsp_denied));

  assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_stop |=> (tx_writable && !tx_draining));

  assert_restart_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_tx_restart && !cmd_tx_stop) |=> (!tx_writable && !tx_draining));

  assert_drain_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_draining && !tx_frame_done && !cmd_tx_stop && !cmd_tx_restart) |=> tx_draining);

  assert_drain_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_writable && tx_draining));

  assert_rx_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_disable |=> rx_writable);

  assert_close_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rx_close_buf && !cmd_rx_enable && !cmd_rx_disable) |=> $stable(rx_writable));

  assert_err_has_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (rsp_valid && rsp_denied && (rsp_rdata == '0)));

  assert_stall_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_denied)));

  // req_addr is part of the observed interface but needs no property of its own
  logic unused_addr;
  assign unused_addr = ^req_addr;

endmodule

bind chan_param_guard pguard_checker #(.AW(AW), .DW(DW)) u_pguard_checker (.*);

// File: tb/tb_chan_param_guard.sv
`timescale 1ns/1ps
module tb_chan_param_guard;

  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_denied;
  logic          cmd_tx_stop = 1'b0;
  logic          cmd_tx_graceful = 1'b0;
  logic          cmd_tx_restart = 1'b0;
  logic          cmd_rx_enable = 1'b0;
  logic          cmd_rx_disable = 1'b0;
  logic          cmd_rx_close_buf = 1'b0;
  logic          tx_frame_done = 1'b0;
  logic          tx_writable;
  logic          tx_draining;
  logic          rx_writable;
  logic          wr_err;
  logic [DW-1:0] rx_max_len;

  always #4 clk = ~clk;

  chan_param_guard dut (.*);

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [DW-1:0] data;
    logic          denied;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference model: 0 running, 1 draining, 2 halted
  int            m_tx = 2;
  bit            m_rx_on = 0;
  logic [DW-1:0] m_mem [16];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected responses as beats are taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected response actual=%0h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " rsp data"},   32'(rsp_rdata),  32'(e.data));
        check({e.tag, " rsp denied"}, 32'(rsp_denied), 32'(e.denied));
      end
    end
  end

  function automatic bit m_allow(logic [AW-1:0] a);
    return a[AW-1] ? !m_rx_on : (m_tx == 2);
  endfunction

  // Driver: one request, expected result queued
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    exp_t e;
    bit   ok;
    ok = m_allow(a);
    e.tag    = tag;
    e.denied = wr && !ok;
    e.data   = wr ? '0 : m_mem[a];
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
    if (wr && ok) m_mem[a] = d;
    @(negedge clk);
    check({tag, " wr_err"}, 32'(wr_err), 32'(wr && !ok));
  endtask

  // Command pulse: mask {close, rxdis, rxen, fdone, restart, graceful, stop}
  task automatic cmd(logic [6:0] m);
    @(posedge clk); #1;
    {cmd_rx_close_buf, cmd_rx_disable, cmd_rx_enable, tx_frame_done,
     cmd_tx_restart, cmd_tx_graceful, cmd_tx_stop} = m;
    @(posedge clk); #1;
    {cmd_rx_close_buf, cmd_rx_disable, cmd_rx_enable, tx_frame_done,
     cmd_tx_restart, cmd_tx_graceful, cmd_tx_stop} = '0;
    if (m[0])      m_tx = 2;
    else if (m[2]) m_tx = 0;
    else if (m_tx == 0 && m[1]) m_tx = 1;
    else if (m_tx == 1 && m[3]) m_tx = 2;
    if (m[5])      m_rx_on = 0;
    else if (m[4]) m_rx_on = 1;
    @(negedge clk);
  endtask

  task automatic status(string tag);
    check({tag, " tx_writable"}, 32'(tx_writable), 32'(m_tx == 2));
    check({tag, " tx_draining"}, 32'(tx_draining), 32'(m_tx == 1));
    check({tag, " rx_writable"}, 32'(rx_writable), 32'(!m_rx_on));
  endtask

  localparam logic [6:0] C_STOP = 7'b0000001, C_GRACE = 7'b0000010,
                         C_RST  = 7'b0000100, C_FDONE = 7'b0001000,
                         C_RXEN = 7'b0010000, C_RXDIS = 7'b0100000,
                         C_CLOSE = 7'b1000000;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    status("R1");
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 wr_err", 32'(wr_err), 0);
    check("R1 rx_max_len", 32'(rx_max_len), 0);
    issue(0, 4'd2, '0, "R1 zero mem");

    // R3/R7/R13 writes while halted and receiver off
    issue(1, 4'd1, 16'h1111, "R3 tx write");
    issue(1, 4'd8, 16'h0200, "R7 rx write");
    check("R10 rx_max_len", 32'(rx_max_len), 32'h0200);
    issue(0, 4'd1, '0, "R13 readback tx");
    issue(0, 4'd8, '0, "R13 readback rx");

    // R5 restart locks tx
    cmd(C_RST); status("R5");
    issue(1, 4'd1, 16'hDEAD, "R9 denied tx write");
    issue(0, 4'd1, '0, "R9 mem unchanged");
    issue(0, 4'd9, '0, "R2 read while running");

    // R12 frame done while running ignored
    cmd(C_FDONE); status("R12 fdone ignored");

    // R4 graceful stop
    cmd(C_GRACE); status("R4 draining");
    issue(1, 4'd3, 16'h3333, "R4 write during drain");
    cmd(7'b0); status("R4 still draining");
    cmd(C_FDONE); status("R4 drained");
    issue(1, 4'd3, 16'h3333, "R4 write after drain");
    issue(0, 4'd3, '0, "R4 readback");

    // R6 stop during drain
    cmd(C_RST); cmd(C_GRACE); status("R6 pre");
    cmd(C_STOP); status("R6 stop in drain");
    cmd(C_RST); cmd(C_STOP); status("R3 stop from running");

    // R7/R8 receiver
    cmd(C_RXEN); status("R7 rx on");
    issue(1, 4'd8, 16'h0400, "R7 rx write denied");
    check("R10 rx_max_len unchanged", 32'(rx_max_len), 32'h0200);
    issue(0, 4'd8, '0, "R2 rx read while on");
    cmd(C_CLOSE); status("R8 close while on");
    issue(1, 4'd10, 16'h0A0A, "R8 write after close");
    cmd(C_RXDIS); status("R7 rx off");
    cmd(C_CLOSE); status("R8 close while off");
    issue(1, 4'd8, 16'h0400, "R7 rx write accepted");
    check("R10 rx_max_len new", 32'(rx_max_len), 32'h0400);

    // R12 priorities
    cmd(C_STOP | C_RST); status("R12 stop over restart");
    cmd(C_GRACE | C_RST); status("R12 restart over graceful");
    cmd(C_RXEN | C_RXDIS); status("R12 disable over enable");

    // R11 back-pressure
    @(posedge clk); #1 rsp_ready = 0;
    issue(0, 4'd3, '0, "R11 first beat");
    check("R11 req_ready low", 32'(req_ready), 0);
    begin
      exp_t e;
      e.data = m_mem[4'd8]; e.denied = 0; e.tag = "R11 second beat";
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = 4'd8;
    repeat (3) @(negedge clk);
    check("R11 held data", 32'(rsp_rdata), 32'h3333);
    check("R11 still stalled", 32'(req_ready), 0);
    @(posedge clk); #1 rsp_ready = 1;
    @(posedge clk); #1 req_valid = 0;
    repeat (3) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule